// File: doc/BRIEF.md
# Byte-Lane Word Memory with Address Hold Register

This block is an on-chip word store of 18-bit words, split into two 9-bit byte lanes. The depth is set by a parameter. The 9-bit lanes leave room for a parity bit per byte. An address hold register sits in front of the array. While the address-capture input is high, the register follows the address bus. While that input is low, it keeps the last address it took. A system that does not need to hold the address ties the capture input high.

All control inputs are active low: a chip select, one select per byte lane, a write strobe and a read-drive enable. Each lane has its own read data and its own drive flag, so a pad wrapper can build tristate pins from them.

With the chip deselected, the block idles and both lanes stay quiet. With the chip selected, the write strobe chooses between a write and a read. Each lane select decides which lanes take part. The read-drive enable gates whether a reading lane actually drives. Everything runs on one system clock: writes commit on the rising edge, and read data is combinational from the held address and the stored contents.

Top module: `wm_bytelane_ram`

## Requirements
- R1: After reset, the held address is 0 and every stored word is 0. A read of both lanes straight after reset therefore drives both lanes with value 0.
- R2: On a rising clock edge with `addr_cap` high, the held address loads `addr_in`. With `addr_cap` low, the held address is unchanged whatever `addr_in` does. Reads and writes always use the held address.
- R3: While `cs_n` is high, neither lane drives and no word is written, whatever the lane selects, `wr_n` and `rd_oe_n` are.
- R4: A write (`cs_n` low, `wr_n` low) with `lsel_lo_n` low stores `wdata[8:0]` into bits 8:0 of the word at the held address on the next rising edge. With `lsel_lo_n` high, those bits are left alone.
- R5: A write with `lsel_hi_n` low stores `wdata[17:9]` into bits 17:9 of the held word on the next rising edge. With `lsel_hi_n` high, those bits are left alone.
- R6: A write with both lane selects high changes no stored bit.
- R7: With `cs_n` low, `wr_n` high and `rd_oe_n` low, each lane whose select is low drives. Its read data equals that lane's bits of the word at the held address (bits 8:0 for the low lane, bits 17:9 for the high lane).
- R8: While `rd_oe_n` is high, neither lane drives, even when a read is otherwise selected.
- R9: During a write (`cs_n` low, `wr_n` low), neither lane drives, whatever `rd_oe_n` is.
- R10: A lane that does not drive presents 0 on its read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears the held address and all words |
| addr_in | input | ADDR_W | Word address bus (ADDR_W = clog2(DEPTH)) |
| addr_cap | input | 1 | High: held address follows `addr_in` at each edge; low: hold |
| cs_n | input | 1 | Active-low chip select |
| lsel_hi_n | input | 1 | Active-low select of the high lane, bits 17:9 |
| lsel_lo_n | input | 1 | Active-low select of the low lane, bits 8:0 |
| wr_n | input | 1 | Active-low write strobe; high selects read |
| rd_oe_n | input | 1 | Active-low read-drive enable |
| wdata | input | 18 | Write data, both lanes |
| rdata_lo | output | 9 | Low-lane read data, 0 when not driving |
| rdata_hi | output | 9 | High-lane read data, 0 when not driving |
| drive_lo | output | 1 | Low lane is driving |
| drive_hi | output | 1 | High lane is driving |

## Verification
The bench builds the block with its default depth of 256 words, so the address is 8 bits wide. Most random addresses fall in a small window, so words get rewritten and read back often and lane merges pile up on the same word. About a quarter of the addresses range over the whole array, which reaches the top word 255. Directed steps after reset cover three cases: the cleared contents, an address held steady while the bus moves, and a write with both selects high.

// File: rtl/wm_pkg.sv
package wm_pkg;
    localparam int LANE_W    = 9;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/wm_addr_latch.sv
module wm_addr_latch #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_cap,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (addr_cap) begin
            st_d.addr = addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q = st_q.addr;

    AST_HOLD_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_cap |=> $stable(addr_q)); // R2
    AST_LOAD_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        addr_cap |=> (addr_q == $past(addr_in))); // R2
endmodule

// File: rtl/wm_lane_decode.sv
module wm_lane_decode
    import wm_pkg::*;
(
    input  logic  cs_n,
    input  logic  wr_n,
    input  logic  rd_oe_n,
    input  logic  sel_n,
    input  lane_t stored,
    output logic  wr_en,
    output logic  drive,
    output lane_t rdata
);
    logic lane_on;

    always_comb begin
        lane_on = !cs_n && !sel_n;
        wr_en   = lane_on && !wr_n;
        drive   = lane_on && wr_n && !rd_oe_n;
        rdata   = drive ? stored : '0;
    end
endmodule

// File: rtl/wm_word_store.sv
module wm_word_store
    import wm_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LANES-1:0] lane_wr,
    input  word_t                wdata,
    output word_t                rword
);
    word_t mem_d [DEPTH];
    word_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (lane_wr[l]) begin
                mem_d[addr][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rword = mem_q[addr];

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr == '0) |=> ((addr != $past(addr)) || (rword == $past(rword)))); // R6
endmodule

// File: rtl/wm_bytelane_ram.sv
module wm_bytelane_ram
    import wm_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_cap,
    input  logic              cs_n,
    input  logic              lsel_hi_n,
    input  logic              lsel_lo_n,
    input  logic              wr_n,
    input  logic              rd_oe_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata_lo,
    output logic [LANE_W-1:0] rdata_hi,
    output logic              drive_lo,
    output logic              drive_hi
);
    logic [ADDR_W-1:0]    addr_q;
    logic [NUM_LANES-1:0] sel_vec_n;
    logic [NUM_LANES-1:0] lane_wr;
    logic [NUM_LANES-1:0] lane_drive;
    lane_t                lane_rd [NUM_LANES];
    word_t                rword;

    assign sel_vec_n = {lsel_hi_n, lsel_lo_n};

    wm_addr_latch #(.ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_cap (addr_cap),
        .addr_in  (addr_in),
        .addr_q   (addr_q)
    );

    wm_word_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr_q),
        .lane_wr (lane_wr),
        .wdata   (wdata),
        .rword   (rword)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        wm_lane_decode u_dec (
            .cs_n    (cs_n),
            .wr_n    (wr_n),
            .rd_oe_n (rd_oe_n),
            .sel_n   (sel_vec_n[g]),
            .stored  (rword[g*LANE_W +: LANE_W]),
            .wr_en   (lane_wr[g]),
            .drive   (lane_drive[g]),
            .rdata   (lane_rd[g])
        );
    end

    assign rdata_lo = lane_rd[0];
    assign rdata_hi = lane_rd[1];
    assign drive_lo = lane_drive[0];
    assign drive_hi = lane_drive[1];

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!drive_lo && !drive_hi && lane_wr == '0)); // R3
    AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe_n |-> (!drive_lo && !drive_hi)); // R8
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n) |-> (!drive_lo && !drive_hi)); // R9
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_n && !rd_oe_n && !lsel_lo_n) |-> drive_lo); // R7
    AST_QUIET_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_hi |-> rdata_hi == '0) and (!drive_lo |-> rdata_lo == '0)); // R10
endmodule

// File: tb/wm_bytelane_ram_test.sv
module wm_bytelane_ram_test;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 256;
    localparam int AW     = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          addr_cap = 1'b0;
    logic          cs_n = 1'b1;
    logic          lsel_hi_n = 1'b1;
    logic          lsel_lo_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          rd_oe_n = 1'b1;
    logic [17:0]   wdata = '0;
    logic [8:0]    rdata_lo, rdata_hi;
    logic          drive_lo, drive_hi;

    int n_checks = 0;
    int n_fail   = 0;
    int ref_mem [DEPTH];
    int ref_addr = 0;

    always #(PERIOD/2) clk = ~clk;

    wm_bytelane_ram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .addr_cap(addr_cap),
        .cs_n(cs_n), .lsel_hi_n(lsel_hi_n), .lsel_lo_n(lsel_lo_n),
        .wr_n(wr_n), .rd_oe_n(rd_oe_n), .wdata(wdata),
        .rdata_lo(rdata_lo), .rdata_hi(rdata_hi),
        .drive_lo(drive_lo), .drive_hi(drive_hi)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs with the behavioural model for the current inputs
    task automatic compare_all();
        bit sel_rd;
        bit e_lo, e_hi;
        int word;
        string dtag;
        sel_rd = !cs_n && wr_n && !rd_oe_n;
        e_lo = sel_rd && !lsel_lo_n;
        e_hi = sel_rd && !lsel_hi_n;
        word = ref_mem[ref_addr];
        dtag = cs_n ? "R3" : (!wr_n ? "R9" : (rd_oe_n ? "R8" : "R7"));
        check(dtag, int'(drive_lo), int'(e_lo));
        check(dtag, int'(drive_hi), int'(e_hi));
        check(e_lo ? "R4" : "R10", int'(rdata_lo), e_lo ? (word & 'h1FF) : 0);
        check(e_hi ? "R5" : "R10", int'(rdata_hi), e_hi ? ((word >> 9) & 'h1FF) : 0);
    endtask

    // model of one rising edge with the currently applied inputs
    task automatic model_edge();
        if (!cs_n && !wr_n) begin
            if (!lsel_lo_n) ref_mem[ref_addr] = (ref_mem[ref_addr] & 'h3FE00) | (int'(wdata) & 'h1FF);
            if (!lsel_hi_n) ref_mem[ref_addr] = (ref_mem[ref_addr] & 'h1FF) | (int'(wdata) & 'h3FE00);
        end
        if (addr_cap) ref_addr = int'(addr_in);
    endtask

    // called at a falling edge: drive, compare before the rising edge, advance
    task automatic apply(input int a, input bit cap, input bit cs, input bit sh,
                         input bit sl, input bit w, input bit oe, input int wd);
        addr_in   = AW'(a);
        addr_cap  = cap;
        cs_n      = cs;
        lsel_hi_n = sh;
        lsel_lo_n = sl;
        wr_n      = w;
        rd_oe_n   = oe;
        wdata     = 18'(wd);
        #1;
        compare_all();
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 0;
        ref_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared contents, both lanes read back 0
        apply(0, 0, 0, 0, 0, 1, 0, 0);
        check("R1", int'({drive_hi, drive_lo}), 3);
        check("R1", int'({rdata_hi, rdata_lo}), 0);

        // R2: capture address 5, write with bus moved and capture low
        apply(5, 1, 0, 0, 0, 1, 0, 0);
        apply(9, 0, 0, 0, 0, 0, 1, 'h2AB3);
        apply(9, 0, 0, 0, 0, 1, 0, 0);
        check("R2", int'({rdata_hi, rdata_lo}), 'h2AB3);

        // R6: write with both selects high leaves the word intact
        apply(9, 0, 0, 1, 1, 0, 0, 'h15555);
        apply(9, 0, 0, 0, 0, 1, 0, 0);
        check("R6", int'({rdata_hi, rdata_lo}), 'h2AB3);

        // R3: deselected write attempt is ignored
        apply(9, 0, 1, 0, 0, 0, 0, 'h3FFFF);
        apply(9, 0, 0, 0, 0, 1, 0, 0);
        check("R3", int'({rdata_hi, rdata_lo}), 'h2AB3);

        // R4 / R5: single-lane writes merge into the word
        apply(9, 0, 0, 1, 0, 0, 1, 'h3FF0F);
        apply(9, 0, 0, 0, 1, 0, 0, 'h0A400);
        apply(9, 0, 0, 0, 0, 1, 0, 0);
        check("R4", int'(rdata_lo), 'h10F);
        check("R5", int'(rdata_hi), 'h052);

        // top word of the array
        apply(DEPTH-1, 1, 0, 0, 0, 1, 1, 0);
        apply(0, 0, 0, 0, 0, 0, 0, 'h3FFFF);
        apply(0, 0, 0, 0, 0, 1, 0, 0);
        check("R7", int'({rdata_hi, rdata_lo}), 'h3FFFF);

        // mixed random traffic, compared every cycle
        for (int k = 0; k < 3000; k++) begin
            int a;
            a = ($urandom % 4 == 0) ? int'($urandom % DEPTH) : int'($urandom % 8);
            apply(a, ($urandom % 3) != 0, ($urandom % 6) == 0, $urandom % 2,
                  $urandom % 2, $urandom % 2, ($urandom % 4) == 0,
                  int'($urandom % 262144));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule